// File: doc/BRIEF.md
# Reloadable Programmable Clock Divider

This block derives a divided clock from its input clock and exposes two memory-mapped words to software: a control word and a ratio word. Software writes a new division ratio into a staging field of the ratio word. The running divider does not see that value yet. The value moves into the divider only when two control bits are set together: a reload-force bit that belongs to this clock, and a shared reload trigger. A half-written ratio therefore never reaches the output. The control word also carries the output gate enable. The ratio word returns both the staged ratio and the ratio currently in use.

Two state machines make up the block.

The phase machine runs the output waveform. It has two states:
- `PH_LOW`: the output low phase.
- `PH_HIGH`: the output high phase.

Its transitions are:
- `PH_LOW`→`PH_HIGH`: the period boundary. This is the only point where a new ratio or a new gate setting takes effect.
- `PH_HIGH`→`PH_LOW`: the mid-period edge.

The reload machine handles the handshake. It has three states:
- `RL_IDLE`: waits for both request bits.
- `RL_ARMED`: a sanitised copy of the staged ratio is held until the next period boundary.
- `RL_HOLD`: the ratio has been applied and the machine waits for software to drop the request.

Its transitions are:
- `RL_IDLE`→`RL_ARMED`: both request bits are seen.
- `RL_ARMED`→`RL_IDLE`: at the boundary, if the request has already dropped.
- `RL_ARMED`→`RL_HOLD`: at the boundary, if the request is still set.
- `RL_HOLD`→`RL_IDLE`: the request drops.

Top module: `reload_clk_divider`

## Requirements
- R1: The control word is at byte offset 0 and the ratio word is at byte offset RATIO_OFFSET (default 8). A write to the ratio word stores bits [13:8] as the staged ratio. A read of the ratio word returns the staged ratio in [13:8] and the active ratio in [21:16], with all other bits zero. A write to any other offset changes nothing.
- R2: After reset the staged ratio is 4 and the active ratio is 4. The control word reads 0x0200_0000, which means the enable (bit 25) is set. The output is low.
- R3: A staged ratio becomes active only when control bit 1 (reload-force) and control bit 8 (reload trigger) are both set. Either bit alone leaves the active ratio unchanged.
- R4: An armed ratio is applied only at the end of a complete output period, at the low-to-high boundary. The active ratio never changes at any other time.
- R5: After a reload, clearing bits 1 and 8 leaves the newly applied ratio active.
- R6: With active ratio N, each output period lasts N input cycles. The high phase lasts floor(N/2) cycles and the low phase lasts N−floor(N/2) cycles, so even ratios give a 50% duty cycle.
- R7: A staged ratio of 0 or 1 is applied as 2. The active ratio is never below 2.
- R8: While control bit 25 is clear the output stays low. The gate setting changes only at a period boundary, and the divider counter keeps running while the output is gated off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register byte offset |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for cfg_addr (combinational) |
| clk_out | output | 1 | Gated divided clock, registered |

## Verification
On every cycle, the assertions check three things. The active ratio and the gate change only at a period boundary. The active ratio never falls below 2. Every high pulse of the output is exactly floor(N/2) cycles long, and the output is never high while the gate is off. Other behaviour only shows up across whole scenarios, so the bench runs them end to end. It covers the register layout, the reset values, and the refusal to reload on a single request bit. It checks that the ratio is retained once the requests are cleared. It sweeps staged ratios 0 to 12 and measures both phases of the resulting clock, and it confirms the output stays low throughout a disabled interval.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [0:0] {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;

    typedef enum logic [1:0] {
        RL_IDLE  = 2'd0,
        RL_ARMED = 2'd1,
        RL_HOLD  = 2'd2
    } reload_t;

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs #(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    parameter int RATIO_OFFSET = 8,
    parameter int RATIO_LSB    = 8,
    parameter int RATIO_W      = 6,
    parameter int ACTIVE_LSB   = 16,
    parameter int FIELD_IDX    = 1,
    parameter int TRIG_BIT     = 8,
    parameter int EN_BIT       = 25,
    parameter int RESET_RATIO  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wr,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic [RATIO_W-1:0] act_ratio,
    output logic [RATIO_W-1:0] staged_ratio,
    output logic               force_req,
    output logic               trig_req,
    output logic               en_req
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR  = '0;
    localparam logic [ADDR_W-1:0] RATIO_ADDR = ADDR_W'(RATIO_OFFSET);
    localparam logic [DATA_W-1:0] CTRL_RST   = DATA_W'(1) << EN_BIT;

    logic [DATA_W-1:0]  ctrl_q;
    logic [RATIO_W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            stage_q <= RATIO_W'(RESET_RATIO);
        end else if (cfg_wr) begin
            if (cfg_addr == CTRL_ADDR)
                ctrl_q <= cfg_wdata;
            else if (cfg_addr == RATIO_ADDR)
                stage_q <= cfg_wdata[RATIO_LSB +: RATIO_W];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == CTRL_ADDR) begin
            cfg_rdata = ctrl_q;
        end else if (cfg_addr == RATIO_ADDR) begin
            cfg_rdata[RATIO_LSB  +: RATIO_W] = stage_q;
            cfg_rdata[ACTIVE_LSB +: RATIO_W] = act_ratio;
        end
    end

    assign staged_ratio = stage_q;
    assign force_req    = ctrl_q[FIELD_IDX];
    assign trig_req     = ctrl_q[TRIG_BIT];
    assign en_req       = ctrl_q[EN_BIT];
endmodule

// File: rtl/clkdiv_reload_ctl.sv
module clkdiv_reload_ctl
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W   = 6,
    parameter int MIN_RATIO = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               force_req,
    input  logic               trig_req,
    input  logic [RATIO_W-1:0] staged_ratio,
    input  logic               per_end,
    output logic               apply_now,
    output logic [RATIO_W-1:0] apply_ratio
);
    localparam logic [RATIO_W-1:0] FLOOR_R = RATIO_W'(MIN_RATIO);

    reload_t            st_q, st_n;
    logic [RATIO_W-1:0] hold_q;
    logic               req;

    assign req = force_req & trig_req;

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            RL_IDLE:  if (req)     st_n = RL_ARMED;
            RL_ARMED: if (per_end) st_n = req ? RL_HOLD : RL_IDLE;
            RL_HOLD:  if (!req)    st_n = RL_IDLE;
            default:               st_n = RL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RL_IDLE;
        else        st_q <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= FLOOR_R;
        else if (st_q == RL_IDLE && req)
            hold_q <= (staged_ratio < FLOOR_R) ? FLOOR_R : staged_ratio;
    end

    assign apply_now   = (st_q == RL_ARMED) && per_end;
    assign apply_ratio = hold_q;
endmodule

// File: rtl/clkdiv_phase_gen.sv
module clkdiv_phase_gen
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W     = 6,
    parameter int RESET_RATIO = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_req,
    input  logic               apply_now,
    input  logic [RATIO_W-1:0] apply_ratio,
    output logic               per_end,
    output logic [RATIO_W-1:0] act_ratio,
    output logic               gate_on,
    output logic               clk_out
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    phase_t             ph_q, ph_n;
    logic [RATIO_W-1:0] cnt_q, cnt_n;
    logic [RATIO_W-1:0] act_q, act_n;
    logic               gate_q, gate_n;
    logic               out_q;
    logic [RATIO_W-1:0] hi_len, lo_len;

    assign hi_len  = act_q >> 1;
    assign lo_len  = act_q - hi_len;
    assign per_end = (ph_q == PH_LOW) && (cnt_q == lo_len - ONE);

    always_comb begin
        ph_n  = ph_q;
        cnt_n = cnt_q + ONE;
        unique case (ph_q)
            PH_LOW: if (cnt_q == lo_len - ONE) begin
                ph_n  = PH_HIGH;
                cnt_n = '0;
            end
            PH_HIGH: if (cnt_q == hi_len - ONE) begin
                ph_n  = PH_LOW;
                cnt_n = '0;
            end
            default: begin
                ph_n  = PH_LOW;
                cnt_n = '0;
            end
        endcase
        act_n  = apply_now ? apply_ratio : act_q;
        gate_n = per_end ? en_req : gate_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_n;
            cnt_q <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= RATIO_W'(RESET_RATIO);
            gate_q <= 1'b1;
            out_q  <= 1'b0;
        end else begin
            act_q  <= act_n;
            gate_q <= gate_n;
            out_q  <= (ph_n == PH_HIGH) && gate_n;
        end
    end

    assign act_ratio = act_q;
    assign gate_on   = gate_q;
    assign clk_out   = out_q;
endmodule

// File: rtl/reload_clk_divider.sv
module reload_clk_divider #(
    parameter int ADDR_W       = 4,
    parameter int DATA_W       = 32,
    parameter int RATIO_OFFSET = 8,
    parameter int RATIO_LSB    = 8,
    parameter int RATIO_W      = 6,
    parameter int ACTIVE_LSB   = 16,
    parameter int FIELD_IDX    = 1,
    parameter int EN_BASE      = 24,
    parameter int TRIG_BIT     = 8,
    parameter int RESET_RATIO  = 4,
    parameter int MIN_RATIO    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              clk_out
);
    localparam int EN_BIT = FIELD_IDX + EN_BASE;

    logic [RATIO_W-1:0] staged_ratio, act_ratio, apply_ratio;
    logic               force_req, trig_req, en_req;
    logic               per_end, apply_now, gate_on;

    clkdiv_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATIO_OFFSET(RATIO_OFFSET),
        .RATIO_LSB(RATIO_LSB), .RATIO_W(RATIO_W), .ACTIVE_LSB(ACTIVE_LSB),
        .FIELD_IDX(FIELD_IDX), .TRIG_BIT(TRIG_BIT), .EN_BIT(EN_BIT),
        .RESET_RATIO(RESET_RATIO)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .act_ratio(act_ratio),
        .staged_ratio(staged_ratio), .force_req(force_req),
        .trig_req(trig_req), .en_req(en_req)
    );

    clkdiv_reload_ctl #(
        .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)
    ) u_reload (
        .clk(clk), .rst_n(rst_n), .force_req(force_req), .trig_req(trig_req),
        .staged_ratio(staged_ratio), .per_end(per_end),
        .apply_now(apply_now), .apply_ratio(apply_ratio)
    );

    clkdiv_phase_gen #(
        .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO)
    ) u_phase (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .apply_now(apply_now),
        .apply_ratio(apply_ratio), .per_end(per_end), .act_ratio(act_ratio),
        .gate_on(gate_on), .clk_out(clk_out)
    );
endmodule

// File: rtl/reload_clk_divider_chk.sv
module reload_clk_divider_chk #(
    parameter int RATIO_W   = 6,
    parameter int MIN_RATIO = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               per_end,
    input logic               gate_on,
    input logic               clk_out,
    input logic [RATIO_W-1:0] act_ratio
);
    logic [RATIO_W-1:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       hi_run <= '0;
        else if (clk_out) hi_run <= hi_run + RATIO_W'(1);
        else              hi_run <= '0;
    end

    AST_RATIO_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !per_end |=> $stable(act_ratio)); // R4

    AST_RATIO_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        act_ratio >= RATIO_W'(MIN_RATIO)); // R7

    AST_GATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !per_end |=> $stable(gate_on)); // R8

    AST_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        clk_out |-> gate_on); // R8

    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_out) |-> hi_run == (act_ratio >> 1)); // R6
endmodule

bind reload_clk_divider reload_clk_divider_chk #(
    .RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)
) u_chk (
    .clk(clk), .rst_n(rst_n), .per_end(per_end), .gate_on(gate_on),
    .clk_out(clk_out), .act_ratio(act_ratio)
);

// File: tb/reload_clk_divider_test.sv
module reload_clk_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        clk_out;
    int          n_chk = 0;
    int          n_bad = 0;

    localparam logic [31:0] EN = 32'h0200_0000;
    localparam logic [31:0] FRC = 32'h0000_0002;
    localparam logic [31:0] TRG = 32'h0000_0100;

    reload_clk_divider uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .clk_out(clk_out)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
        cfg_addr = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Finds a rising edge, then counts the high and low cycles of one period.
    task automatic measure(output int hi, output int lo);
        int guard;
        hi = 0; lo = 0; guard = 0;
        while (clk_out && guard < 200) begin @(negedge clk); guard++; end
        while (!clk_out && guard < 200) begin @(negedge clk); guard++; end
        while (clk_out && guard < 400) begin @(negedge clk); hi++; guard++; end
        while (!clk_out && guard < 600) begin @(negedge clk); lo++; guard++; end
    endtask

    task automatic reload(input int ratio, input logic [31:0] ctl);
        wr(4'h8, 32'(ratio) << 8);
        wr(4'h0, ctl);
        idle(40);
        wr(4'h0, EN);
        idle(40);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int hi, lo, e;
        #1;
        check("R2 output low in reset", int'(clk_out), 0);
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 output low after reset", int'(clk_out), 0);
        rd(4'h0, d);
        check("R2 control reset value", int'(d), int'(EN));
        rd(4'h8, d);
        check("R2 R1 staged ratio at reset", int'(d[13:8]), 4);
        check("R2 R1 active ratio at reset", int'(d[21:16]), 4);
        check("R1 unused ratio bits", int'(d & ~32'h003F_3F00), 0);
        measure(hi, lo);
        check("R6 reset high phase", hi, 2);
        check("R6 reset low phase", lo, 2);

        // R3: force alone, trigger alone
        reload(6, EN | FRC);
        rd(4'h8, d);
        check("R3 force alone keeps active", int'(d[21:16]), 4);
        check("R1 staged readback", int'(d[13:8]), 6);
        reload(6, EN | TRG);
        rd(4'h8, d);
        check("R3 trigger alone keeps active", int'(d[21:16]), 4);
        measure(hi, lo);
        check("R3 period unchanged", hi + lo, 4);

        // R3 R5: both bits, then cleared
        reload(6, EN | FRC | TRG);
        rd(4'h8, d);
        check("R3 R5 ratio applied and kept", int'(d[21:16]), 6);
        measure(hi, lo);
        check("R5 high phase after clear", hi, 3);
        check("R5 low phase after clear", lo, 3);

        // R1: write to unmapped offset ignored
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h0, d);
        check("R1 unmapped write, control", int'(d), int'(EN));
        rd(4'h8, d);
        check("R1 unmapped write, staged", int'(d[13:8]), 6);

        // R6 R7 R4: sweep staged ratios
        for (int r = 0; r <= 12; r++) begin
            e = (r < 2) ? 2 : r;
            reload(r, EN | FRC | TRG);
            rd(4'h8, d);
            check("R7 R4 active after sweep reload", int'(d[21:16]), e);
            measure(hi, lo);
            check("R6 sweep high phase", hi, e / 2);
            check("R6 sweep low phase", lo, e - e / 2);
        end

        // R8: gate off holds the output low, gate on resumes
        reload(5, EN | FRC | TRG);
        wr(4'h0, 32'h0);
        idle(20);
        e = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (clk_out) e++;
        end
        check("R8 output low while disabled", e, 0);
        wr(4'h0, EN);
        measure(hi, lo);
        check("R8 high phase after enable", hi, 2);
        check("R8 low phase after enable", lo, 3);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule